// File: doc/BRIEF.md
# Security region OTP controller

This block guards a small one-time-programmable security region inside a parallel NOR flash model. It receives already-decoded commands through a command channel. The commands are read, enter-region, exit-region, program, erase, protect and protect-verify. It decides whether each address lands in the security window, and it applies flash-style program-only rules to a compact internal array of region words. The window's location depends on two static configuration pins: the boot option (top or bottom) and the bus mode (byte or word).

The region is reachable only while region mode is active. An enter command turns region mode on. An exit command or a reset turns it off. Erase aimed at the region is always refused. Programming can only clear bits. A protect command sets a lock that nothing but a power-up reset clears, and after that every program attempt on the region is refused. Accelerated programs and unlock-bypass programs are refused whenever they target the region. Each refused command raises a one-cycle error pulse.

Commands enter on a valid/ready channel. Every accepted command produces exactly one result beat on a valid/ready result channel. The result register holds one entry. While a result is held and `res_ready` is low, `cmd_ready` is low and the result beat stays unchanged. A command is accepted on a rising clock edge where `cmd_valid` and `cmd_ready` are both high. Its result appears in the following cycle.

Top module: `sec_otp_ctrl`

## Requirements
- R1: After reset, `res_valid` and `err_pulse` are 0 and `cmd_ready` is 1. Region mode is off, the lock is clear and every region word reads 16'hFFFF.
- R2: In word mode, the window is word addresses 000000h–000007h for bottom boot (`top_boot`=0) and 1FF000h–1FF007h for top boot. In byte mode it is byte addresses 000000h–00000Fh (bottom) or 3FE000h–3FE00Fh (top). A read inside the window in region mode returns the region data with `res_hit`=1. Any other read returns 16'hFFFF with `res_hit`=0.
- R3: Outside region mode, reads of window addresses return 16'hFFFF with `res_hit`=0, and program commands leave the region unchanged without error. Op codes: read=0, enter=1, exit=2, program=3, erase=4, protect=5, verify=6.
- R4: A program in region mode inside the window replaces the addressed word with old AND write data, so bits only go from 1 to 0.
- R5: In byte mode, region byte b maps to word b>>1: its low half when b is even and its high half when b is odd. A byte read returns {8'h00, byte}. A byte program ANDs `cmd_wdata[7:0]` into that byte only.
- R6: An erase in region mode inside the window is rejected with an error and leaves the region contents unchanged.
- R7: A region program with `cmd_accel`=1 or `cmd_bypass`=1 is rejected with an error and changes nothing.
- R8: A protect in region mode sets the lock permanently. Exit and enter do not clear it. Once locked, every region program is rejected with an error and changes nothing.
- R9: A verify returns the lock state in `res_data[0]` with all other bits 0. Non-read, non-verify commands return `res_data`=0.
- R10: Every rejected command sets `res_err`=1 on its result beat and pulses `err_pulse` for exactly the cycle that beat first appears. Accepted commands give 0 on both.
- R11: While `res_valid`=1 and `res_ready`=0, the result beat stays stable and `cmd_ready`=0. When `res_ready` returns high with no new command, `res_valid` falls on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, models power-up |
| top_boot | input | 1 | 1 selects the top-boot window, 0 the bottom |
| byte_mode | input | 1 | 1 treats addresses as byte addresses, 0 as word addresses |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be taken this cycle |
| cmd_op | input | 3 | Decoded operation code |
| cmd_addr | input | 22 | Byte or word address |
| cmd_wdata | input | 16 | Program data |
| cmd_accel | input | 1 | Program requested in accelerated mode |
| cmd_bypass | input | 1 | Program requested in unlock-bypass mode |
| res_valid | output | 1 | Result beat present |
| res_ready | input | 1 | Result consumer can take the beat |
| res_data | output | 16 | Read data or lock status |
| res_err | output | 1 | Command was rejected |
| res_hit | output | 1 | Read was served from the region |
| err_pulse | output | 1 | One-cycle flag for each rejected command |

## Verification
A corrupted region word shows at the ports on the next region read, one cycle after that read is accepted. A stray lock or a lost lock shows on the next verify result, or as an unexpected error on a program. A region-mode bit that is stuck on or off flips `res_hit` and the read pattern for window addresses. The bench also follows each tested address through every boot and bus-mode combination, so a decoder that puts the window in the wrong place returns the all-ones pattern in place of written data.

// File: rtl/sec_otp_pkg.sv
`timescale 1ns/1ps
package sec_otp_pkg;
  typedef enum logic [2:0] {
    OP_READ   = 3'd0,
    OP_ENTER  = 3'd1,
    OP_EXIT   = 3'd2,
    OP_PROG   = 3'd3,
    OP_ERASE  = 3'd4,
    OP_PROT   = 3'd5,
    OP_VERIFY = 3'd6,
    OP_NONE   = 3'd7
  } sec_op_e;
endpackage

// File: rtl/sec_win_dec.sv
`timescale 1ns/1ps
// Address-to-window decoder; the window moves with boot option and bus mode.
module sec_win_dec #(
  parameter int ADDR_W          = 22,
  parameter int REGION_WORDS    = 8,
  parameter int BOOT_SECT_BYTES = 8192,
  localparam int WI_W           = $clog2(REGION_WORDS)
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              top_boot,
  input  logic              byte_mode,
  output logic              hit,
  output logic [WI_W-1:0]   word_idx,
  output logic              hi_sel
);
  localparam longint unsigned WORD_SPAN = 64'd1 << (ADDR_W - 1);
  localparam longint unsigned TOP_WORD  = WORD_SPAN - longint'(BOOT_SECT_BYTES / 2);
  localparam logic [ADDR_W-2:0] TOP_WBASE = (ADDR_W-1)'(TOP_WORD);

  logic [ADDR_W-2:0] wbase;
  logic [ADDR_W-1:0] bbase;
  logic              hit_w;
  logic              hit_b;

  always_comb begin
    wbase = top_boot ? TOP_WBASE : '0;
    bbase = {wbase, 1'b0};
    hit_w = addr[ADDR_W-2:WI_W] == wbase[ADDR_W-2:WI_W];
    hit_b = addr[ADDR_W-1:WI_W+1] == bbase[ADDR_W-1:WI_W+1];
    if (byte_mode) begin
      hit      = hit_b;
      word_idx = addr[WI_W:1];
      hi_sel   = addr[0];
    end else begin
      hit      = hit_w;
      word_idx = addr[WI_W-1:0];
      hi_sel   = 1'b0;
    end
  end
endmodule

// File: rtl/sec_otp_array.sv
`timescale 1ns/1ps
// Region storage: powers up erased, each write can only clear bits.
module sec_otp_array #(
  parameter int REGION_WORDS = 8,
  parameter int WORD_W       = 16,
  localparam int WI_W        = $clog2(REGION_WORDS),
  localparam int BYTE_W      = WORD_W / 2,
  localparam int MEM_W       = REGION_WORDS * WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WI_W-1:0]   wr_idx,
  input  logic              wr_byte,
  input  logic              wr_hi,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [WI_W-1:0]   rd_idx,
  output logic [WORD_W-1:0] rd_word,
  output logic [MEM_W-1:0]  mem_flat
);
  logic [WORD_W-1:0] and_mask;

  always_comb begin
    if (!wr_byte)
      and_mask = wr_data;
    else if (wr_hi)
      and_mask = {wr_data[BYTE_W-1:0], {BYTE_W{1'b1}}};
    else
      and_mask = {{BYTE_W{1'b1}}, wr_data[BYTE_W-1:0]};
  end

  for (genvar gi = 0; gi < REGION_WORDS; gi++) begin : g_word
    logic [WORD_W-1:0] cell_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        cell_q <= '1;
      else if (wr_en && (wr_idx == WI_W'(gi)))
        cell_q <= cell_q & and_mask;
    end
    assign mem_flat[gi*WORD_W +: WORD_W] = cell_q;
  end

  assign rd_word = mem_flat[rd_idx*WORD_W +: WORD_W];
endmodule

// File: rtl/sec_otp_state.sv
`timescale 1ns/1ps
// Region-mode flag and the sticky protect lock.
module sec_otp_state (
  input  logic clk,
  input  logic rst_n,
  input  logic enter_ev,
  input  logic exit_ev,
  input  logic protect_ev,
  output logic region_mode,
  output logic locked
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      region_mode <= 1'b0;
      locked      <= 1'b0;
    end else begin
      if (exit_ev)
        region_mode <= 1'b0;
      else if (enter_ev)
        region_mode <= 1'b1;
      if (protect_ev)
        locked <= 1'b1;
    end
  end
endmodule

// File: rtl/sec_otp_ctrl.sv
`timescale 1ns/1ps
module sec_otp_ctrl
  import sec_otp_pkg::*;
#(
  parameter int ADDR_W          = 22,
  parameter int WORD_W          = 16,
  parameter int REGION_WORDS    = 8,
  parameter int BOOT_SECT_BYTES = 8192,
  localparam int WI_W           = $clog2(REGION_WORDS),
  localparam int BYTE_W         = WORD_W / 2,
  localparam int MEM_W          = REGION_WORDS * WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              top_boot,
  input  logic              byte_mode,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [WORD_W-1:0] cmd_wdata,
  input  logic              cmd_accel,
  input  logic              cmd_bypass,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [WORD_W-1:0] res_data,
  output logic              res_err,
  output logic              res_hit,
  output logic              err_pulse
);
  sec_op_e           op;
  logic              fire;
  logic              win_hit;
  logic [WI_W-1:0]   word_idx;
  logic              hi_sel;
  logic              region_mode;
  logic              locked_q;
  logic              target;
  logic              prog_req;
  logic              prog_bad;
  logic              erase_bad;
  logic              reject;
  logic              wr_en;
  logic [WORD_W-1:0] rd_word;
  logic [MEM_W-1:0]  mem_flat;
  logic [WORD_W-1:0] rd_view;
  logic [WORD_W-1:0] res_next;

  assign op        = sec_op_e'(cmd_op);
  assign cmd_ready = !res_valid || res_ready;
  assign fire      = cmd_valid && cmd_ready;

  sec_win_dec #(
    .ADDR_W(ADDR_W), .REGION_WORDS(REGION_WORDS), .BOOT_SECT_BYTES(BOOT_SECT_BYTES)
  ) dec_i (
    .addr(cmd_addr), .top_boot(top_boot), .byte_mode(byte_mode),
    .hit(win_hit), .word_idx(word_idx), .hi_sel(hi_sel)
  );

  sec_otp_state state_i (
    .clk(clk), .rst_n(rst_n),
    .enter_ev(fire && op == OP_ENTER),
    .exit_ev(fire && op == OP_EXIT),
    .protect_ev(fire && op == OP_PROT && region_mode),
    .region_mode(region_mode), .locked(locked_q)
  );

  always_comb begin
    target    = region_mode && win_hit;
    prog_req  = fire && op == OP_PROG && target;
    prog_bad  = prog_req && (cmd_accel || cmd_bypass || locked_q);
    erase_bad = fire && op == OP_ERASE && target;
    reject    = prog_bad || erase_bad;
    wr_en     = prog_req && !prog_bad;
  end

  sec_otp_array #(
    .REGION_WORDS(REGION_WORDS), .WORD_W(WORD_W)
  ) array_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(word_idx),
    .wr_byte(byte_mode), .wr_hi(hi_sel), .wr_data(cmd_wdata),
    .rd_idx(word_idx), .rd_word(rd_word), .mem_flat(mem_flat)
  );

  always_comb begin
    if (!target)
      rd_view = '1;
    else if (!byte_mode)
      rd_view = rd_word;
    else if (hi_sel)
      rd_view = {{BYTE_W{1'b0}}, rd_word[WORD_W-1:BYTE_W]};
    else
      rd_view = {{BYTE_W{1'b0}}, rd_word[BYTE_W-1:0]};
    case (op)
      OP_READ:   res_next = rd_view;
      OP_VERIFY: res_next = {{(WORD_W-1){1'b0}}, locked_q};
      default:   res_next = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_data  <= '0;
      res_err   <= 1'b0;
      res_hit   <= 1'b0;
      err_pulse <= 1'b0;
    end else begin
      err_pulse <= reject;
      if (fire) begin
        res_valid <= 1'b1;
        res_data  <= res_next;
        res_err   <= reject;
        res_hit   <= (op == OP_READ) && target;
      end else if (res_ready) begin
        res_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sec_otp_chk.sv
`timescale 1ns/1ps
module sec_otp_chk #(
  parameter int WORD_W = 16,
  parameter int MEM_W  = 128
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [2:0]        cmd_op,
  input logic              res_valid,
  input logic              res_ready,
  input logic [WORD_W-1:0] res_data,
  input logic              res_err,
  input logic              err_pulse,
  input logic              locked,
  input logic [MEM_W-1:0]  mem_flat
);
  logic fire;
  assign fire = cmd_valid && cmd_ready;

  p_no_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_flat & ~$past(mem_flat)) == '0);

  p_erase_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fire && cmd_op == 3'd4 |=> $stable(mem_flat));

  p_lock_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked);

  p_lock_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    locked && fire && cmd_op == 3'd3 |=> $stable(mem_flat));

  p_verify_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fire && cmd_op == 3'd6 |=> res_data == {{(WORD_W-1){1'b0}}, $past(locked)});

  p_err_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> res_valid && res_err && $past(fire));

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_data) && $stable(res_err));
endmodule

bind sec_otp_ctrl sec_otp_chk #(.WORD_W(WORD_W), .MEM_W(MEM_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_op(cmd_op), .res_valid(res_valid), .res_ready(res_ready),
  .res_data(res_data), .res_err(res_err), .err_pulse(err_pulse),
  .locked(locked_q), .mem_flat(mem_flat)
);

// File: tb/sec_otp_ctrl_tb_top.sv
`timescale 1ns/1ps
module sec_otp_ctrl_tb_top;
  localparam logic [2:0] RD = 3'd0, EN = 3'd1, EX = 3'd2, PG = 3'd3,
                         ER = 3'd4, PT = 3'd5, VF = 3'd6;

  typedef struct packed {
    logic [2:0]  op;
    logic        top;
    logic        bmode;
    logic        accel;
    logic        bypass;
    logic [21:0] addr;
    logic [15:0] wdata;
    logic [15:0] exp;
    logic        exp_err;
    logic        exp_hit;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 45;
  localparam vec_t VECS [NV] = '{
    '{VF, 1'b0,1'b0,1'b0,1'b0, 22'h000000, 16'h0000, 16'h0000, 1'b0,1'b0, 4'd9},  // R9 unlocked
    '{RD, 1'b0,1'b0,1'b0,1'b0, 22'h000000, 16'h0000, 16'hFFFF, 1'b0,1'b0, 4'd3},  // R3 not in mode
    '{EN, 1'b0,1'b0,1'b0,1'b0, 22'h000000, 16'h0000, 16'h0000, 1'b0,1'b0, 4'd3},
    '{RD, 1'b0,1'b0,1'b0,1'b0, 22'h000000, 16'h0000, 16'hFFFF, 1'b0,1'b1, 4'd2},  // R2 erased
    '{PG, 1'b0,1'b0,1'b0,1'b0, 22'h000000, 16'h12F0, 16'h0000, 1'b0,1'b0, 4'd4},
    '{RD, 1'b0,1'b0,1'b0,1'b0, 22'h000000, 16'h0000, 16'h12F0, 1'b0,1'b1, 4'd4},  // R4
    '{PG, 1'b0,1'b0,1'b0,1'b0, 22'h000000, 16'hFF0F, 16'h0000, 1'b0,1'b0, 4'd4},
    '{RD, 1'b0,1'b0,1'b0,1'b0, 22'h000000, 16'h0000, 16'h1200, 1'b0,1'b1, 4'd4},  // R4 AND
    '{RD, 1'b0,1'b0,1'b0,1'b0, 22'h000008, 16'h0000, 16'hFFFF, 1'b0,1'b0, 4'd2},  // R2 past end
    '{PG, 1'b0,1'b0,1'b0,1'b0, 22'h000007, 16'hA5A5, 16'h0000, 1'b0,1'b0, 4'd4},
    '{RD, 1'b0,1'b0,1'b0,1'b0, 22'h000007, 16'h0000, 16'hA5A5, 1'b0,1'b1, 4'd2},  // R2 last word
    '{ER, 1'b0,1'b0,1'b0,1'b0, 22'h000000, 16'h0000, 16'h0000, 1'b1,1'b0, 4'd6},  // R6
    '{RD, 1'b0,1'b0,1'b0,1'b0, 22'h000000, 16'h0000, 16'h1200, 1'b0,1'b1, 4'd6},  // R6 kept
    '{PG, 1'b0,1'b0,1'b1,1'b0, 22'h000001, 16'h0000, 16'h0000, 1'b1,1'b0, 4'd7},  // R7 accel
    '{PG, 1'b0,1'b0,1'b0,1'b1, 22'h000001, 16'h0000, 16'h0000, 1'b1,1'b0, 4'd7},  // R7 bypass
    '{RD, 1'b0,1'b0,1'b0,1'b0, 22'h000001, 16'h0000, 16'hFFFF, 1'b0,1'b1, 4'd7},  // R7 kept
    '{RD, 1'b0,1'b1,1'b0,1'b0, 22'h000000, 16'h0000, 16'h0000, 1'b0,1'b1, 4'd5},  // R5 byte 0
    '{RD, 1'b0,1'b1,1'b0,1'b0, 22'h000001, 16'h0000, 16'h0012, 1'b0,1'b1, 4'd5},  // R5 byte 1
    '{RD, 1'b0,1'b1,1'b0,1'b0, 22'h00000F, 16'h0000, 16'h00A5, 1'b0,1'b1, 4'd5},  // R5 byte 15
    '{PG, 1'b0,1'b1,1'b0,1'b0, 22'h000003, 16'h003C, 16'h0000, 1'b0,1'b0, 4'd5},
    '{RD, 1'b0,1'b1,1'b0,1'b0, 22'h000010, 16'h0000, 16'hFFFF, 1'b0,1'b0, 4'd2},  // R2 byte end
    '{RD, 1'b0,1'b1,1'b0,1'b0, 22'h000003, 16'h0000, 16'h003C, 1'b0,1'b1, 4'd5},
    '{RD, 1'b0,1'b0,1'b0,1'b0, 22'h000001, 16'h0000, 16'h3CFF, 1'b0,1'b1, 4'd5},  // R5 high half
    '{RD, 1'b1,1'b0,1'b0,1'b0, 22'h000000, 16'h0000, 16'hFFFF, 1'b0,1'b0, 4'd2},  // R2 top moves
    '{RD, 1'b1,1'b0,1'b0,1'b0, 22'h1FF000, 16'h0000, 16'h1200, 1'b0,1'b1, 4'd2},
    '{RD, 1'b1,1'b0,1'b0,1'b0, 22'h1FF007, 16'h0000, 16'hA5A5, 1'b0,1'b1, 4'd2},
    '{RD, 1'b1,1'b0,1'b0,1'b0, 22'h1FF008, 16'h0000, 16'hFFFF, 1'b0,1'b0, 4'd2},
    '{RD, 1'b1,1'b0,1'b0,1'b0, 22'h1FEFFF, 16'h0000, 16'hFFFF, 1'b0,1'b0, 4'd2},
    '{RD, 1'b1,1'b1,1'b0,1'b0, 22'h3FE000, 16'h0000, 16'h0000, 1'b0,1'b1, 4'd2},
    '{RD, 1'b1,1'b1,1'b0,1'b0, 22'h3FE003, 16'h0000, 16'h003C, 1'b0,1'b1, 4'd5},
    '{RD, 1'b1,1'b1,1'b0,1'b0, 22'h3FE010, 16'h0000, 16'hFFFF, 1'b0,1'b0, 4'd2},
    '{RD, 1'b1,1'b1,1'b0,1'b0, 22'h1FF000, 16'h0000, 16'hFFFF, 1'b0,1'b0, 4'd2},  // R2 word addr in byte mode
    '{EX, 1'b1,1'b0,1'b0,1'b0, 22'h000000, 16'h0000, 16'h0000, 1'b0,1'b0, 4'd3},
    '{RD, 1'b1,1'b0,1'b0,1'b0, 22'h1FF000, 16'h0000, 16'hFFFF, 1'b0,1'b0, 4'd3},  // R3 after exit
    '{PG, 1'b1,1'b0,1'b0,1'b0, 22'h1FF002, 16'h0000, 16'h0000, 1'b0,1'b0, 4'd3},
    '{EN, 1'b1,1'b0,1'b0,1'b0, 22'h000000, 16'h0000, 16'h0000, 1'b0,1'b0, 4'd3},
    '{RD, 1'b1,1'b0,1'b0,1'b0, 22'h1FF002, 16'h0000, 16'hFFFF, 1'b0,1'b1, 4'd3},  // R3 program ignored
    '{PT, 1'b1,1'b0,1'b0,1'b0, 22'h000000, 16'h0000, 16'h0000, 1'b0,1'b0, 4'd8},
    '{VF, 1'b1,1'b0,1'b0,1'b0, 22'h000000, 16'h0000, 16'h0001, 1'b0,1'b0, 4'd9},  // R9 locked
    '{PG, 1'b1,1'b0,1'b0,1'b0, 22'h1FF002, 16'h0000, 16'h0000, 1'b1,1'b0, 4'd8},  // R8 refused
    '{RD, 1'b1,1'b0,1'b0,1'b0, 22'h1FF002, 16'h0000, 16'hFFFF, 1'b0,1'b1, 4'd8},
    '{EX, 1'b1,1'b0,1'b0,1'b0, 22'h000000, 16'h0000, 16'h0000, 1'b0,1'b0, 4'd8},
    '{EN, 1'b1,1'b0,1'b0,1'b0, 22'h000000, 16'h0000, 16'h0000, 1'b0,1'b0, 4'd8},
    '{VF, 1'b1,1'b0,1'b0,1'b0, 22'h000000, 16'h0000, 16'h0001, 1'b0,1'b0, 4'd8},  // R8 sticky
    '{ER, 1'b1,1'b0,1'b0,1'b0, 22'h1FF000, 16'h0000, 16'h0000, 1'b1,1'b0, 4'd6}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        top_boot = 1'b0;
  logic        byte_mode = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [2:0]  cmd_op = 3'd0;
  logic [21:0] cmd_addr = '0;
  logic [15:0] cmd_wdata = '0;
  logic        cmd_accel = 1'b0;
  logic        cmd_bypass = 1'b0;
  logic        res_valid;
  logic        res_ready = 1'b1;
  logic [15:0] res_data;
  logic        res_err;
  logic        res_hit;
  logic        err_pulse;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sec_otp_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .top_boot(top_boot), .byte_mode(byte_mode),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_accel(cmd_accel),
    .cmd_bypass(cmd_bypass), .res_valid(res_valid), .res_ready(res_ready),
    .res_data(res_data), .res_err(res_err), .res_hit(res_hit), .err_pulse(err_pulse)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Present one command at a falling edge; it is taken at the next rising
  // edge and its result is sampled at the falling edge after that.
  task automatic do_cmd(input logic [2:0] op, input logic [21:0] addr,
                        input logic [15:0] wd, input logic ac, input logic bp);
    cmd_op = op; cmd_addr = addr; cmd_wdata = wd;
    cmd_accel = ac; cmd_bypass = bp; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_accel = 1'b0; cmd_bypass = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R11 watchdog expired actual=hung expected=finished");
      finish_run();
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 res_valid after reset", 32'(res_valid), 32'd0);
    chk("R1 cmd_ready after reset", 32'(cmd_ready), 32'd1);
    chk("R1 err_pulse after reset", 32'(err_pulse), 32'd0);

    for (int i = 0; i < NV; i++) begin
      top_boot  = VECS[i].top;
      byte_mode = VECS[i].bmode;
      do_cmd(VECS[i].op, VECS[i].addr, VECS[i].wdata, VECS[i].accel, VECS[i].bypass);
      chk($sformatf("R%0d vec%0d valid", VECS[i].req, i), 32'(res_valid), 32'd1);
      chk($sformatf("R%0d vec%0d data", VECS[i].req, i), 32'(res_data), 32'(VECS[i].exp));
      chk($sformatf("R%0d vec%0d hit", VECS[i].req, i), 32'(res_hit), 32'(VECS[i].exp_hit));
      chk($sformatf("R10 vec%0d res_err", i), 32'(res_err), 32'(VECS[i].exp_err));
      chk($sformatf("R10 vec%0d err_pulse", i), 32'(err_pulse), 32'(VECS[i].exp_err));
    end

    // R10 error pulse lasts one cycle (still top boot, word mode, in region mode)
    top_boot = 1'b1; byte_mode = 1'b0;
    do_cmd(ER, 22'h1FF001, 16'h0000, 1'b0, 1'b0);
    chk("R10 err_pulse on reject", 32'(err_pulse), 32'd1);
    @(negedge clk);
    chk("R10 err_pulse one cycle", 32'(err_pulse), 32'd0);
    chk("R11 res_valid drops when idle", 32'(res_valid), 32'd0);

    // R11 back-pressure on the result channel
    res_ready = 1'b0;
    do_cmd(VF, 22'h000000, 16'h0000, 1'b0, 1'b0);
    chk("R11 beat present", 32'(res_valid), 32'd1);
    chk("R11 cmd_ready low while stalled", 32'(cmd_ready), 32'd0);
    repeat (2) @(negedge clk);
    chk("R11 beat held", 32'(res_valid), 32'd1);
    chk("R11 data held", 32'(res_data), 32'h0001);
    chk("R11 cmd_ready still low", 32'(cmd_ready), 32'd0);
    res_ready = 1'b1;
    @(negedge clk);
    chk("R11 beat drained", 32'(res_valid), 32'd0);
    chk("R11 cmd_ready back", 32'(cmd_ready), 32'd1);

    // R1 reset again: power-up clears lock, mode and contents
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 res_valid in reset", 32'(res_valid), 32'd0);
    chk("R1 cmd_ready in reset", 32'(cmd_ready), 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    do_cmd(VF, 22'h000000, 16'h0000, 1'b0, 1'b0);
    chk("R1 lock clear after reset", 32'(res_data), 32'h0000);
    do_cmd(RD, 22'h1FF000, 16'h0000, 1'b0, 1'b0);
    chk("R1 mode off after reset hit", 32'(res_hit), 32'd0);
    do_cmd(EN, 22'h000000, 16'h0000, 1'b0, 1'b0);
    do_cmd(RD, 22'h1FF000, 16'h0000, 1'b0, 1'b0);
    chk("R1 erased after reset data", 32'(res_data), 32'hFFFF);
    chk("R1 erased after reset hit", 32'(res_hit), 32'd1);

    finish_run();
  end
endmodule